// File: doc/BRIEF.md
# Double-Buffered Byte-Wide DAC Front End

This block is the synchronous digital front end of a 12-bit voltage-output converter that is fed from an 8-bit parallel bus. A host writes a code in two byte halves. A high-byte-select input picks which half of an input register each write fills. A separate DAC register holds the code that actually drives the converter. The spare upper bits of a high-byte write carry two analog settings: the reference buffer enable and the output amplifier gain.

All host pins are asynchronous to the system clock. They pass through a synchronizer before any decision is made. A write commits on the rising edge of the active-low write strobe. The active-low load strobe moves the input register into the DAC register. It does this either inside the same write, or as a level-held update while chip select is inactive. An active-low clear zeroes both code registers. An active-low power-down input raises an output-disabled flag and leaves all stored state untouched.

Top module: `dac_byte_front`

## Requirements
- R1: A write with `hb_sel`=0 places `bus[7:0]` into input-register bits 7:0. Bits 11:8 are left unchanged.
- R2: A write with `hb_sel`=1 places `bus[3:0]` into input-register bits 11:8. Bits 7:0 are left unchanged.
- R3: A high-byte write captures `bus[4]` into `ref_buffered` (1 = buffered) and `bus[5]` into `gain_double` (1 = double gain). A low-byte write and a clear leave both settings unchanged.
- R4: A write is accepted only on a rising edge of `wr_n` while `cs_n`=0 and `clr_n`=1. A `wr_n` edge with `cs_n`=1 changes nothing.
- R5: When `ld_n`=0 during an accepted write, the DAC register takes the full 12-bit input-register value in the same clock, including the half just written.
- R6: When `ld_n`=0 and `cs_n`=1, the DAC register copies the input register on every clock. With `ld_n`=1, `dac_code` holds its value.
- R7: When `clr_n`=0, both the input and DAC registers are zeroed regardless of the other inputs. A write attempted during clear is ignored.
- R8: After reset, `dac_code`=0, `ref_buffered`=0, `gain_double`=0 and `out_hiz`=0.
- R9: When `pd_n`=0, `out_hiz` is 1. Register contents are not altered by entering or leaving power-down.
- R10: A change on an input pin reaches the registered outputs on the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; a write commits on its rising edge |
| hb_sel | input | 1 | Half select: 0 low byte, 1 high byte |
| ld_n | input | 1 | Load strobe into the DAC register, active low |
| clr_n | input | 1 | Clear of both code registers, active low |
| pd_n | input | 1 | Power-down request, active low |
| bus | input | 8 | Parallel data bus |
| dac_code | output | 12 | Code presented to the converter |
| ref_buffered | output | 1 | Reference buffer enable setting |
| gain_double | output | 1 | Output amplifier gain setting |
| out_hiz | output | 1 | Output disabled (three-state) during power-down |

## Verification
The bench writes each half with the load strobe held inactive and checks that `dac_code` does not move until a later load. A design that wires the input register straight to the output would fail this check. It loads a low byte within the write itself to catch a DAC register that latches the input register one cycle stale and misses the new half. A write strobe with chip select inactive, a write during clear, and a low-byte write all leave the captured settings alone. A design with loose decoding would corrupt them. The bench also counts the exact edge on which a load strobe appears at the output, which exposes a missing or extra synchronizer stage.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

   // synchronized host control pins
   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic hb_sel;
      logic ld_n;
      logic clr_n;
      logic pd_n;
   } host_ctl_t;

   localparam int unsigned CTL_W = $bits(host_ctl_t);

   // idle level of each control pin
   localparam host_ctl_t CTL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, hb_sel: 1'b0,
                                      ld_n: 1'b1, clr_n: 1'b1, pd_n: 1'b1};

   // decoded per-clock actions
   typedef struct packed {
      logic wr_accept;
      logic hb_sel;
      logic dac_load;
      logic clr_act;
   } reg_cmd_t;

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dbf_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dbf_strobe.sv
module dbf_strobe
   import dbf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  host_ctl_t ctl,
   output reg_cmd_t  cmd
);

   logic wr_prev;
   logic wr_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b1;
      else        wr_prev <= ctl.wr_n;
   end

   // rising edge of the active-low write strobe ends a write
   assign wr_rise = ctl.wr_n & ~wr_prev;

   always_comb begin
      cmd.clr_act   = ~ctl.clr_n;
      cmd.hb_sel    = ctl.hb_sel;
      cmd.wr_accept = wr_rise & ~ctl.cs_n & ctl.clr_n;
      cmd.dac_load  = ctl.clr_n & ~ctl.ld_n & (ctl.cs_n | cmd.wr_accept);
   end

   // R4: the edge detector yields single-cycle pulses
   p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |=> !wr_rise);

   // R4: nothing is accepted while deselected
   p_no_write_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cs_n |-> !cmd.wr_accept);

endmodule

// File: rtl/dbf_regs.sv
module dbf_regs
   import dbf_pkg::*;
#(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_cmd_t          cmd,
   input  logic [BUS_W-1:0]  bus_s,
   output logic [DATA_W-1:0] dac_q,
   output logic              ref_buf_q,
   output logic              gain2_q
);

   localparam int unsigned HI_W    = DATA_W - BUS_W;
   localparam int unsigned REF_BIT = HI_W;
   localparam int unsigned GAIN_BIT = HI_W + 1;

   if (DATA_W <= BUS_W || HI_W + 2 > BUS_W) begin : g_bad_widths
      $error("dbf_regs: high byte must hold the upper code bits and two settings");
   end

   logic [DATA_W-1:0] in_reg;
   logic [DATA_W-1:0] in_next;

   always_comb begin
      in_next = in_reg;
      if (cmd.wr_accept) begin
         if (cmd.hb_sel) in_next[DATA_W-1:BUS_W] = bus_s[HI_W-1:0];
         else            in_next[BUS_W-1:0]      = bus_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_reg <= '0;
         dac_q  <= '0;
      end else if (cmd.clr_act) begin
         in_reg <= '0;
         dac_q  <= '0;
      end else begin
         in_reg <= in_next;
         if (cmd.dac_load) dac_q <= in_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_buf_q <= 1'b0;
         gain2_q   <= 1'b0;
      end else if (cmd.wr_accept && cmd.hb_sel) begin
         ref_buf_q <= bus_s[REF_BIT];
         gain2_q   <= bus_s[GAIN_BIT];
      end
   end

   p_low_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.wr_accept && !cmd.hb_sel) |=> in_reg[BUS_W-1:0] == $past(bus_s));

   p_high_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.wr_accept && cmd.hb_sel) |=> in_reg[DATA_W-1:BUS_W] == $past(bus_s[HI_W-1:0]));

   p_ctrl_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.wr_accept && cmd.hb_sel) |=> (ref_buf_q == $past(bus_s[REF_BIT]))
                                     && (gain2_q == $past(bus_s[GAIN_BIT])));

   p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd.wr_accept && cmd.hb_sel) |=> $stable(ref_buf_q) && $stable(gain2_q));

   p_load_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dac_load && !cmd.clr_act) |=> dac_q == in_reg);

   p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.dac_load && !cmd.clr_act) |=> $stable(dac_q));

   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.clr_act |=> (dac_q == '0) && (in_reg == '0));

endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
   import dbf_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              hb_sel,
   input  logic              ld_n,
   input  logic              clr_n,
   input  logic              pd_n,
   input  logic [BUS_W-1:0]  bus,
   output logic [DATA_W-1:0] dac_code,
   output logic              ref_buffered,
   output logic              gain_double,
   output logic              out_hiz
);

   host_ctl_t        ctl_raw;
   host_ctl_t        ctl_s;
   logic [CTL_W-1:0] ctl_vec_s;
   logic [BUS_W-1:0] bus_s;
   reg_cmd_t         cmd;

   assign ctl_raw = '{cs_n: cs_n, wr_n: wr_n, hb_sel: hb_sel,
                      ld_n: ld_n, clr_n: clr_n, pd_n: pd_n};

   dbf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_vec_s));

   dbf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst_n(rst_n), .d(bus), .q(bus_s));

   assign ctl_s = host_ctl_t'(ctl_vec_s);

   dbf_strobe u_strobe (.clk(clk), .rst_n(rst_n), .ctl(ctl_s), .cmd(cmd));

   dbf_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bus_s(bus_s),
      .dac_q(dac_code), .ref_buf_q(ref_buffered), .gain2_q(gain_double));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_hiz <= 1'b0;
      else        out_hiz <= ~ctl_s.pd_n;
   end

   p_hiz_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_s.pd_n |=> out_hiz);

   p_hiz_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_s.pd_n |=> !out_hiz);

endmodule

// File: tb/sim_dac_byte_front.sv
module sim_dac_byte_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, wr_n = 1'b1, hb_sel = 1'b0;
   logic        ld_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
   logic [7:0]  bus = '0;
   logic [11:0] dac_code;
   logic        ref_buffered, gain_double, out_hiz;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dac_byte_front u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .hb_sel(hb_sel),
      .ld_n(ld_n), .clr_n(clr_n), .pd_n(pd_n), .bus(bus),
      .dac_code(dac_code), .ref_buffered(ref_buffered),
      .gain_double(gain_double), .out_hiz(out_hiz));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic hb, input logic [7:0] d, input logic ld);
      cs_n = 1'b0; hb_sel = hb; bus = d; ld_n = ~ld;
      repeat (3) @(negedge clk);
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b1; ld_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic load_only();
      cs_n = 1'b1; ld_n = 1'b0;
      repeat (4) @(negedge clk);
      ld_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R8 dac_code", dac_code, 0);
      chk("R8 ref_buffered", ref_buffered, 0);
      chk("R8 gain_double", gain_double, 0);
      chk("R8 out_hiz", out_hiz, 0);
   endtask

   task automatic t_halves();
      wr_byte(1'b0, 8'hA5, 1'b0);
      chk("R6 hold without load", dac_code, 0);
      load_only();
      chk("R1 low half then load", dac_code, 12'h0A5);
      wr_byte(1'b1, 8'hB3, 1'b0);
      chk("R6 hold after high write", dac_code, 12'h0A5);
      chk("R3 ref from bit4", ref_buffered, 1);
      chk("R3 gain from bit5", gain_double, 1);
      load_only();
      chk("R2 high half then load", dac_code, 12'h3A5);
   endtask

   task automatic t_load_in_write();
      wr_byte(1'b0, 8'h5C, 1'b1);
      chk("R5 load inside write", dac_code, 12'h35C);
      chk("R3 low write keeps ref", ref_buffered, 1);
      wr_byte(1'b1, 8'h17, 1'b1);
      chk("R5 high half loaded in write", dac_code, 12'h75C);
      chk("R3 ref set", ref_buffered, 1);
      chk("R3 gain cleared", gain_double, 0);
   endtask

   task automatic t_deselected();
      cs_n = 1'b1; hb_sel = 1'b0; bus = 8'hEE;
      repeat (3) @(negedge clk);
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      load_only();
      chk("R4 write ignored when deselected", dac_code, 12'h75C);
   endtask

   task automatic t_powerdown();
      pd_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 out_hiz in power-down", out_hiz, 1);
      chk("R9 code kept in power-down", dac_code, 12'h75C);
      pd_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 out_hiz released", out_hiz, 0);
      load_only();
      chk("R9 input register kept", dac_code, 12'h75C);
   endtask

   task automatic t_clear();
      clr_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 clear zeroes dac", dac_code, 0);
      chk("R3 clear keeps ref", ref_buffered, 1);
      wr_byte(1'b0, 8'hFF, 1'b1);
      chk("R7 write during clear ignored", dac_code, 0);
      clr_n = 1'b1;
      repeat (4) @(negedge clk);
      load_only();
      chk("R7 input register zeroed", dac_code, 0);
   endtask

   task automatic t_latency();
      wr_byte(1'b0, 8'h11, 1'b0);
      ld_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 no change after two edges", dac_code, 0);
      @(negedge clk);
      chk("R10 change on third edge", dac_code, 12'h011);
      ld_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_halves();
      t_load_in_write();
      t_deselected();
      t_powerdown();
      t_clear();
      t_latency();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule